// File: doc/BRIEF.md
# Dual-Port PHY Reset and Strap Capture Controller

This block sequences resets for the two ports of a 10/100 Ethernet physical-layer device and captures each port's power-up configuration from strap inputs. Each port can be reset in three ways:

- The active-low hardware reset pin, held low long enough to qualify.
- A management write that sets the self-clearing reset bit in that port's control register.
- The controller's own synchronous reset.

A port in reset shows a busy flag. This flag drives the reset of the port's registers and is also the value read back from the self-clearing bit.

When a port's reset period ends, the strap levels on that last clock are frozen into the port's configuration:

- The upper four bits of a 5-bit management address.
- A node/repeater selection.
- A fiber (100Base-FX) selection.
- For port 0 only, an automatic MII isolate when every address strap is 0.

Bit 0 of each address is the port index. Outside a reset period the straps are ignored, because the same pins may later serve as outputs.

Top module: `phy_rst_strap_ctrl`

## Requirements
- R1: A low pulse on `hw_rst_n` sampled on fewer than HW_MIN_CYC consecutive rising edges has no effect on `rst_busy` or on any configuration output.
- R2: Once `hw_rst_n` has been sampled low on HW_MIN_CYC consecutive edges, both bits of `rst_busy` are 1 from the next cycle. They stay 1 while the pin stays low, and clear SEQ_CYC edges after the last edge that samples the pin low.
- R3: A write strobe with `reg_wr_addr` = 0 and `reg_wr_rst_bit` = 1 starts a reset of the port chosen by `reg_wr_port`. That port's `rst_busy` bit reads 1 for exactly SEQ_CYC cycles after the write edge, then reads 0. The other port is unaffected.
- R4: A write with `reg_wr_rst_bit` = 0, or to any address other than 0, has no effect.
- R5: On the edge where a port's `rst_busy` falls, `strap_addr` is stored into bits 4:1 of that port's address field. The port's address field is `port_addr[5*p+4:5*p]`.
- R6: Bit 0 of a port's address is 0 for port 0 and 1 for port 1, whatever the straps are.
- R7: On that same edge, `strap_mode[p]` is stored into `port_repeater[p]` (1 = repeater, 0 = node) and `strap_fiber[p]` into `port_fiber[p]` (1 = 100Base-FX).
- R8: `mii_isolate[0]` is 1 exactly when port 0's captured address bits 4:1 are all 0. `mii_isolate[1]` is always 0.
- R9: While a port is not busy, changes on the strap inputs do not alter its configuration outputs.
- R10: A qualified hardware reset that arrives during a software reset restarts the sequence of both ports.
- R11: A software reset write to a port that is already busy restarts that port's SEQ_CYC-cycle count.
- R12: While `rst` is high, both ports are busy. The address of port 0 is 00000 and of port 1 is 00001, both flags are 0, and `mii_isolate` is 01. Both ports then finish a full SEQ_CYC sequence after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| hw_rst_n | input | 1 | Hardware reset pin, active low, synchronous to clk |
| reg_wr_en | input | 1 | Management register write strobe |
| reg_wr_port | input | 1 | Port targeted by the write |
| reg_wr_addr | input | 5 | Register address of the write |
| reg_wr_rst_bit | input | 1 | Value written to the self-clearing reset bit (bit 15) |
| strap_addr | input | 4 | Shared address straps |
| strap_mode | input | 2 | Per-port repeater strap |
| strap_fiber | input | 2 | Per-port fiber strap |
| port_addr | output | 10 | Per-port 5-bit management address, port p at [5p+4:5p] |
| port_repeater | output | 2 | 1 = repeater mode, 0 = node mode |
| port_fiber | output | 2 | 1 = 100Base-FX |
| mii_isolate | output | 2 | MII isolate per port |
| rst_busy | output | 2 | Port in reset / self-clearing bit read-back |

## Verification
A trigger, whether a qualifying low edge or a reset write, shows as `rst_busy` high one cycle after the edge that samples it. The configuration outputs change only one cycle after the edge where busy falls, and they carry the straps present at that edge. The reference model in the bench advances on the same rising edge as the design, using the inputs the bench drove on the preceding falling edge. Every output is compared at each falling edge, so each result is checked in the first cycle it is due and in every cycle after that. Pulses one cycle shorter than the qualification length, strap changes on the final busy clock, and restarts issued mid-sequence place the expected transitions exactly at the boundaries.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
  localparam int NUM_PORTS   = 2;
  localparam int MGMT_ADDR_W = 5;
  localparam int STRAP_ADDR_W = MGMT_ADDR_W - 1;

  typedef struct packed {
    logic [MGMT_ADDR_W-1:0] addr;
    logic                   repeater;
    logic                   fiber;
    logic                   isolate;
  } port_cfg_t;
endpackage

// File: rtl/hw_rst_qual.sv
module hw_rst_qual #(
  parameter int HW_MIN_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic hw_trig
);
  localparam int LO_W = $clog2(HW_MIN_CYC + 1);

  logic [LO_W-1:0] lo_cnt;

  // trigger on the edge that completes the qualifying low run, and every edge after it
  assign hw_trig = !pin_n && (lo_cnt >= LO_W'(HW_MIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || pin_n) begin
      lo_cnt <= '0;
    end else if (lo_cnt != LO_W'(HW_MIN_CYC)) begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  AST_SHORT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (pin_n && $past(pin_n)) |-> !hw_trig) else $error("trigger without low pin"); // R1
endmodule

// File: rtl/port_rst_seq.sv
module port_rst_seq
  import phy_rst_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int SEQ_CYC  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reload,
  input  logic [STRAP_ADDR_W-1:0] strap_addr,
  input  logic                    strap_mode,
  input  logic                    strap_fiber,
  output logic                    busy,
  output port_cfg_t               cfg
);
  localparam int CNT_W = $clog2(SEQ_CYC + 1);
  localparam logic ADDR_LSB = (PORT_IDX != 0);
  localparam port_cfg_t CFG_DEFAULT = '{
    addr:     {{STRAP_ADDR_W{1'b0}}, ADDR_LSB},
    repeater: 1'b0,
    fiber:    1'b0,
    isolate:  (PORT_IDX == 0)
  };

  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             iso_next;

  assign last = !reload && (cnt == CNT_W'(1));

  generate
    if (PORT_IDX == 0) begin : g_iso
      assign iso_next = (strap_addr == '0);
    end else begin : g_no_iso
      assign iso_next = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CNT_W'(SEQ_CYC);
      busy <= 1'b1;
    end else if (reload) begin
      cnt  <= CNT_W'(SEQ_CYC);
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CNT_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_DEFAULT;
    end else if (last) begin
      cfg.addr     <= {strap_addr, ADDR_LSB};
      cfg.repeater <= strap_mode;
      cfg.fiber    <= strap_fiber;
      cfg.isolate  <= iso_next;
    end
  end

  AST_RELOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    reload |=> busy) else $error("reload did not raise busy"); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && !reload) |=> $stable(cfg)) else $error("config moved while idle"); // R9
  AST_CAPTURE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cfg.addr[MGMT_ADDR_W-1:1] == $past(strap_addr)
                     && cfg.repeater == $past(strap_mode)
                     && cfg.fiber == $past(strap_fiber))) else $error("capture mismatch"); // R5
endmodule

// File: rtl/phy_rst_strap_ctrl.sv
module phy_rst_strap_ctrl
  import phy_rst_pkg::*;
#(
  parameter int HW_MIN_CYC = 250000,
  parameter int SEQ_CYC    = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              hw_rst_n,
  input  logic                              reg_wr_en,
  input  logic                              reg_wr_port,
  input  logic [MGMT_ADDR_W-1:0]            reg_wr_addr,
  input  logic                              reg_wr_rst_bit,
  input  logic [STRAP_ADDR_W-1:0]           strap_addr,
  input  logic [NUM_PORTS-1:0]              strap_mode,
  input  logic [NUM_PORTS-1:0]              strap_fiber,
  output logic [NUM_PORTS*MGMT_ADDR_W-1:0]  port_addr,
  output logic [NUM_PORTS-1:0]              port_repeater,
  output logic [NUM_PORTS-1:0]              port_fiber,
  output logic [NUM_PORTS-1:0]              mii_isolate,
  output logic [NUM_PORTS-1:0]              rst_busy
);
  localparam logic [MGMT_ADDR_W-1:0] CTRL_REG_ADDR = '0;

  logic                 hw_trig;
  logic                 sw_hit;
  logic [NUM_PORTS-1:0] reload;

  hw_rst_qual #(.HW_MIN_CYC(HW_MIN_CYC)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .pin_n   (hw_rst_n),
    .hw_trig (hw_trig)
  );

  assign sw_hit = reg_wr_en && reg_wr_rst_bit && (reg_wr_addr == CTRL_REG_ADDR);

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      port_cfg_t cfg;

      assign reload[p] = hw_trig || (sw_hit && (reg_wr_port == 1'(p)));

      port_rst_seq #(.PORT_IDX(p), .SEQ_CYC(SEQ_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .reload      (reload[p]),
        .strap_addr  (strap_addr),
        .strap_mode  (strap_mode[p]),
        .strap_fiber (strap_fiber[p]),
        .busy        (rst_busy[p]),
        .cfg         (cfg)
      );

      assign port_addr[p*MGMT_ADDR_W +: MGMT_ADDR_W] = cfg.addr;
      assign port_repeater[p] = cfg.repeater;
      assign port_fiber[p]    = cfg.fiber;
      assign mii_isolate[p]   = cfg.isolate;
    end
  endgenerate

  AST_HW_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
    hw_trig |=> (rst_busy == '1)) else $error("hw reset missed a port"); // R2
  AST_ISOLATE_MATCH: assert property (@(posedge clk) disable iff (rst)
    mii_isolate[0] == (port_addr[MGMT_ADDR_W-1:1] == '0)) else $error("isolate mismatch"); // R8
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_rst_bit && !hw_trig && rst_busy == '0) |=> (rst_busy == '0))
    else $error("write without reset bit started a reset"); // R4
endmodule

// File: tb/test_phy_rst_strap_ctrl.sv
`timescale 1ns/1ps
module test_phy_rst_strap_ctrl;
  localparam int N = 6;
  localparam int S = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_rst_n = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic       reg_wr_port = 1'b0;
  logic [4:0] reg_wr_addr = '0;
  logic       reg_wr_rst_bit = 1'b0;
  logic [3:0] strap_addr = '0;
  logic [1:0] strap_mode = '0;
  logic [1:0] strap_fiber = '0;
  logic [9:0] port_addr;
  logic [1:0] port_repeater, port_fiber, mii_isolate, rst_busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  phy_rst_strap_ctrl #(.HW_MIN_CYC(N), .SEQ_CYC(S)) i_phy_rst_strap_ctrl (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_port(reg_wr_port), .reg_wr_addr(reg_wr_addr),
    .reg_wr_rst_bit(reg_wr_rst_bit), .strap_addr(strap_addr), .strap_mode(strap_mode),
    .strap_fiber(strap_fiber), .port_addr(port_addr), .port_repeater(port_repeater),
    .port_fiber(port_fiber), .mii_isolate(mii_isolate), .rst_busy(rst_busy)
  );

  always #2 clk = ~clk;

  // behavioural reference
  int lo_run = 0;
  int rem [2];
  logic [4:0] e_addr [2];
  logic e_rep [2], e_fib [2], e_iso [2];

  always @(posedge clk) begin
    bit hw;
    started <= 1'b1;
    if (rst) begin
      lo_run = 0;
      for (int p = 0; p < 2; p++) begin
        rem[p] = S; e_addr[p] = 5'(p); e_rep[p] = 0; e_fib[p] = 0; e_iso[p] = (p == 0);
      end
    end else begin
      hw = !hw_rst_n && (lo_run + 1 >= N);
      lo_run = hw_rst_n ? 0 : ((lo_run < N) ? lo_run + 1 : N);
      for (int p = 0; p < 2; p++) begin
        bit req;
        req = reg_wr_en && (reg_wr_port == p) && (reg_wr_addr == 0) && reg_wr_rst_bit;
        if (hw || req) rem[p] = S;
        else if (rem[p] > 0) begin
          rem[p]--;
          if (rem[p] == 0) begin
            e_addr[p] = {strap_addr, 1'(p)};
            e_rep[p] = strap_mode[p];
            e_fib[p] = strap_fiber[p];
            e_iso[p] = (p == 0) && (strap_addr == 0);
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int p = 0; p < 2; p++) begin
        chk("R1 R2 R3 R4 R10 R11 R12 rst_busy", int'(rst_busy[p]), int'(rem[p] > 0));
        chk("R5 R6 R9 R12 port_addr", int'(port_addr[p*5 +: 5]), int'(e_addr[p]));
        chk("R7 R9 port_repeater", int'(port_repeater[p]), int'(e_rep[p]));
        chk("R7 R9 port_fiber", int'(port_fiber[p]), int'(e_fib[p]));
        chk("R8 mii_isolate", int'(mii_isolate[p]), int'(e_iso[p]));
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic port, logic [4:0] addr, logic bit15);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_port = port; reg_wr_addr = addr; reg_wr_rst_bit = bit15;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_rst_bit = 1'b0;
  endtask

  task automatic hw_pulse(int len);
    @(negedge clk);
    hw_rst_n = 1'b0;
    cycles(len);
    hw_rst_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    // R12: defaults and initial sequence
    cycles(3);
    strap_addr = 4'h5; strap_mode = 2'b10; strap_fiber = 2'b01;
    rst = 1'b0;
    cycles(S + 3);
    // R9: straps move while idle
    strap_addr = 4'h0; strap_mode = 2'b01; strap_fiber = 2'b10;
    cycles(3);
    // R1: pulse one edge short
    hw_pulse(N - 1);
    cycles(S + 3);
    // R2: qualified hw reset, straps all zero -> R8 isolate on port 0
    hw_pulse(N + 3);
    cycles(S + 3);
    // R3: sw reset port 1 with new straps, capture on last clock (R5, R6, R7)
    strap_addr = 4'hA; strap_mode = 2'b11; strap_fiber = 2'b11;
    wr(1'b1, 5'd0, 1'b1);
    cycles(S - 2);
    strap_addr = 4'h3;
    cycles(4);
    // R4: bit clear, and wrong address
    wr(1'b0, 5'd0, 1'b0);
    wr(1'b0, 5'h19, 1'b1);
    cycles(S + 2);
    // R3 on port 0, then R11 restart mid-sequence
    strap_addr = 4'h8; strap_mode = 2'b00; strap_fiber = 2'b00;
    wr(1'b0, 5'd0, 1'b1);
    cycles(2);
    wr(1'b0, 5'd0, 1'b1);
    cycles(S + 3);
    // R10: hw reset arrives during port 1 sw reset
    strap_addr = 4'hF; strap_mode = 2'b01;
    wr(1'b1, 5'd0, 1'b1);
    hw_pulse(N);
    cycles(S + 3);
    // R12: controller reset again
    @(negedge clk); rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(S + 3);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule